// File: doc/BRIEF.md
# Receive Byte Queue with Data Holding Register

This block is the receive-side buffer of a serial port. Bytes arrive from a deserializer as a data byte with a one-cycle valid strobe. They enter a 16-entry byte queue, and the oldest queued byte moves on its own into one visible data register. A software read of that register is a one-cycle pop strobe. The pop frees the register, and the next queued byte takes its place.

Status is computed over the combined occupancy: the queue plus the data register. A fill-level flag rises once a programmable number of bytes is held, and a full flag rises once every storage place is taken. A sticky overrun flag records a byte that arrived with nowhere to go. The fill-level flag and the full flag each raise an interrupt request only when that flag's own enable is set. The deserializer, baud timing, parity and framing checks, and register decoding are outside the block. Plain strobes stand in for them.

Top module: `rxq_holdreg`

## Requirements
- R1: A synchronous active-high reset empties the queue and the data register. It also clears every flag and interrupt request.
- R2: When the data register is empty and the queue holds a byte, the oldest byte is in the data register after the next clock edge. `data_vld` then reads 1.
- R3: Bytes leave through `data_out` in arrival order. A pop with `data_vld` high frees the register, and the next byte, if any, replaces it at the same edge.
- R4: `thr_flag` is high when the stored count (queue plus data register) is at least the level that `thr_code` selects. The codes are 0→2, 1→4, 2→8, 3→12, 4→14, and 5→16 (15 in the queue plus 1 in the register).
- R5: With `thr_code` set to 6 or 7, `thr_flag` stays low at any fill.
- R6: `full_flag` is high exactly when the stored count equals the queue depth plus one.
- R7: The 17th byte received without a pop does not raise overrun. The 18th byte does.
- R8: An overrun discards the arriving byte and sets `ovr_flag`. The flag stays set until an `ovr_clr` pulse clears it, and a new overrun in the same cycle as the pulse wins.
- R9: A push and a pop in the same cycle leave the stored count unchanged, including when the block is full. Such a cycle raises no overrun.
- R10: `thr_irq` equals `thr_flag` AND `thr_ie`, and `full_irq` equals `full_flag` AND `full_ie`. All of these are taken from the same edge.
- R11: A pop while `data_vld` is low has no effect on the contents or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rd_pop | input | 1 | Software read of the data register |
| thr_code | input | 3 | Fill-level selection code |
| thr_ie | input | 1 | Fill-level interrupt enable |
| full_ie | input | 1 | Full interrupt enable |
| ovr_clr | input | 1 | Write-one-to-clear strobe for overrun |
| data_out | output | 8 | Data register contents |
| data_vld | output | 1 | Data register holds a byte |
| thr_flag | output | 1 | Fill level reached |
| full_flag | output | 1 | Queue and data register both full |
| ovr_flag | output | 1 | Sticky overrun |
| thr_irq | output | 1 | Gated fill-level interrupt request |
| full_irq | output | 1 | Gated full interrupt request |

## Verification
The hardest case is the full boundary: 17 bytes stored while a push and a pop land in the same cycle. A queue-full check that ignores the refill of the data register would then report a false overrun. The stimulus reaches this case by pushing 18 bytes back to back with no pops, which also exercises the 17th-versus-18th overrun edge. It then issues a combined push and pop and clears the overrun afterwards. Each fill-level code is swept over every occupancy from 0 to 17, and a pseudo-random push/pop mix follows. Every cycle is compared against an occupancy model kept in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Byte count that sets the fill-level flag; depth+2 can never be reached.
  function automatic int unsigned thr_level(input logic [2:0] code, input int unsigned depth);
    case (code)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (3 * depth) / 4;
      3'd4:    return (7 * depth) / 8;
      3'd5:    return depth;
      default: return depth + 2;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // The read register doubles as the visible data register (read-first).
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int TOTW = $clog2(DEPTH + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic            mem_re,
  output logic [AW-1:0]   mem_raddr,
  output logic            hold_vld,
  output logic [CNTW-1:0] fifo_cnt,
  output logic [TOTW-1:0] total_nxt,
  output logic            ovr_evt
);
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] cnt_nxt;
  logic            fifo_pop, fifo_full, hold_nxt;

  always_comb begin
    fifo_full = (fifo_cnt == CNTW'(DEPTH));
    fifo_pop  = (fifo_cnt != '0) && (!hold_vld || pop);
    ovr_evt   = push && fifo_full && !fifo_pop;
    mem_we    = push && !ovr_evt;
    cnt_nxt   = fifo_cnt + CNTW'(mem_we) - CNTW'(fifo_pop);
    if (fifo_pop)   hold_nxt = 1'b1;
    else if (pop)   hold_nxt = 1'b0;
    else            hold_nxt = hold_vld;
    total_nxt = TOTW'(cnt_nxt) + TOTW'(hold_nxt);
  end

  assign mem_waddr = wr_ptr;
  assign mem_raddr = rd_ptr;
  assign mem_re    = fifo_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fifo_cnt <= '0;
      hold_vld <= 1'b0;
    end else begin
      if (mem_we)   wr_ptr <= wr_ptr + 1'b1;
      if (fifo_pop) rd_ptr <= rd_ptr + 1'b1;
      fifo_cnt <= cnt_nxt;
      hold_vld <= hold_nxt;
    end
  end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int DEPTH = 16,
  localparam int TOTW = $clog2(DEPTH + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TOTW-1:0] total_nxt,
  input  logic [2:0]      thr_code,
  input  logic            thr_ie,
  input  logic            full_ie,
  input  logic            ovr_evt,
  input  logic            ovr_clr,
  output logic            thr_flag,
  output logic            full_flag,
  output logic            ovr_flag,
  output logic            thr_irq,
  output logic            full_irq
);
  logic [TOTW-1:0] level;
  logic            thr_nxt, full_nxt;

  always_comb begin
    level    = TOTW'(rxq_pkg::thr_level(thr_code, DEPTH));
    thr_nxt  = (total_nxt >= level);
    full_nxt = (total_nxt == TOTW'(DEPTH + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_flag  <= 1'b0;
      full_flag <= 1'b0;
      ovr_flag  <= 1'b0;
      thr_irq   <= 1'b0;
      full_irq  <= 1'b0;
    end else begin
      thr_flag  <= thr_nxt;
      full_flag <= full_nxt;
      thr_irq   <= thr_nxt && thr_ie;
      full_irq  <= full_nxt && full_ie;
      if (ovr_evt)      ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_holdreg.sv
module rxq_holdreg #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int TOTW = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rd_pop,
  input  logic [2:0]    thr_code,
  input  logic          thr_ie,
  input  logic          full_ie,
  input  logic          ovr_clr,
  output logic [DW-1:0] data_out,
  output logic          data_vld,
  output logic          thr_flag,
  output logic          full_flag,
  output logic          ovr_flag,
  output logic          thr_irq,
  output logic          full_irq
);
  logic            mem_we, mem_re, ovr_evt;
  logic [AW-1:0]   mem_waddr, mem_raddr;
  logic [CNTW-1:0] fifo_cnt;
  logic [TOTW-1:0] total_nxt;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push(rx_valid), .pop(rd_pop),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .hold_vld(data_vld), .fifo_cnt(fifo_cnt), .total_nxt(total_nxt), .ovr_evt(ovr_evt)
  );

  rxq_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(rx_data),
    .re(mem_re), .raddr(mem_raddr), .rdata(data_out)
  );

  rxq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .total_nxt(total_nxt), .thr_code(thr_code),
    .thr_ie(thr_ie), .full_ie(full_ie), .ovr_evt(ovr_evt), .ovr_clr(ovr_clr),
    .thr_flag(thr_flag), .full_flag(full_flag), .ovr_flag(ovr_flag),
    .thr_irq(thr_irq), .full_irq(full_irq)
  );
endmodule

// File: rtl/rxq_holdreg_chk.sv
module rxq_holdreg_chk #(
  parameter int DEPTH = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            rx_valid,
  input logic            rd_pop,
  input logic            ovr_clr,
  input logic [2:0]      thr_code,
  input logic            data_vld,
  input logic            thr_flag,
  input logic            full_flag,
  input logic            ovr_flag,
  input logic [CNTW-1:0] fifo_cnt
);
  // R2: a waiting byte reaches the empty data register on the next edge
  assert_hold_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (!data_vld && fifo_cnt != '0) |=> data_vld);

  // R6: full means both the queue and the register are occupied
  assert_full_both_R6: assert property (@(posedge clk) disable iff (rst)
    full_flag |-> (data_vld && fifo_cnt == CNTW'(DEPTH)));

  // R7: the queue count never exceeds its depth
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CNTW'(DEPTH));

  // R8: overrun is sticky until cleared
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  // R9: combined push and pop at full keeps it full with no new overrun
  assert_full_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (full_flag && rx_valid && rd_pop && !ovr_flag && !ovr_clr) |=> (full_flag && !ovr_flag));

  // R5: disabled codes never raise the fill-level flag
  assert_thr_off_R5: assert property (@(posedge clk) disable iff (rst)
    (thr_code >= 3'd6) |=> !thr_flag);
endmodule

bind rxq_holdreg rxq_holdreg_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rd_pop(rd_pop), .ovr_clr(ovr_clr),
  .thr_code(thr_code), .data_vld(data_vld), .thr_flag(thr_flag),
  .full_flag(full_flag), .ovr_flag(ovr_flag), .fifo_cnt(fifo_cnt)
);

// File: tb/rxq_holdreg_tb.sv
module rxq_holdreg_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rd_pop = 1'b0;
  logic [2:0] thr_code = 3'd5;
  logic       thr_ie = 1'b0;
  logic       full_ie = 1'b0;
  logic       ovr_clr = 1'b0;
  logic [7:0] data_out;
  logic       data_vld, thr_flag, full_flag, ovr_flag, thr_irq, full_irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model
  int mq [0:31];
  int mcnt, mhd;
  bit mhv, movr;

  always #2 clk = ~clk;

  rxq_holdreg u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rd_pop(rd_pop),
    .thr_code(thr_code), .thr_ie(thr_ie), .full_ie(full_ie), .ovr_clr(ovr_clr),
    .data_out(data_out), .data_vld(data_vld), .thr_flag(thr_flag),
    .full_flag(full_flag), .ovr_flag(ovr_flag), .thr_irq(thr_irq), .full_irq(full_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_level(input logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      3'd4: return 14;
      3'd5: return 16;
      default: return 99;
    endcase
  endfunction

  task automatic compare();
    int tot;
    bit et;
    tot = mcnt + int'(mhv);
    et  = (tot >= exp_level(thr_code));
    chk("R2 data_vld", int'(data_vld), int'(mhv));
    if (mhv) chk("R3 data_out", int'(data_out), mhd);
    chk("R4 thr_flag", int'(thr_flag), int'(et));
    chk("R6 full_flag", int'(full_flag), int'(tot == 17));
    chk("R8 ovr_flag", int'(ovr_flag), int'(movr));
    chk("R10 thr_irq", int'(thr_irq), int'(et && thr_ie));
    chk("R10 full_irq", int'(full_irq), int'((tot == 17) && full_ie));
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic step(input bit push, input int d, input bit pop, input bit clr);
    bit fpop, ov;
    rx_valid = push; rx_data = d[7:0]; rd_pop = pop; ovr_clr = clr;
    fpop = (mcnt > 0) && (!mhv || pop);
    ov   = push && (mcnt == 16) && !fpop;
    if (fpop) begin
      mhd = mq[0];
      for (int i = 0; i < 31; i++) mq[i] = mq[i+1];
      mcnt--;
      mhv = 1;
    end else if (pop) mhv = 0;
    if (push && !ov) begin mq[mcnt] = d & 255; mcnt++; end
    if (ov) movr = 1; else if (clr) movr = 0;
    @(posedge clk); #1;
    compare();
    @(negedge clk);
    rx_valid = 0; rd_pop = 0; ovr_clr = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    mcnt = 0; mhv = 0; movr = 0; mhd = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lfsr;
    int seq;
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk("R1 data_vld", int'(data_vld), 0);
    chk("R1 flags", int'({thr_flag, full_flag, ovr_flag, thr_irq, full_irq}), 0);

    // Fill to the overrun boundary with code 5
    thr_code = 3'd5; thr_ie = 1; full_ie = 1;
    seq = 0;
    for (int n = 1; n <= 17; n++) begin step(1, seq, 0, 0); seq++; end
    chk("R7 no overrun at 17th", int'(ovr_flag), 0);
    chk("R6 full at 17", int'(full_flag), 1);
    step(1, 8'hEE, 0, 0);
    chk("R7 overrun at 18th", int'(ovr_flag), 1);
    // R9: combined push/pop at full
    step(1, seq, 1, 0); seq++;
    chk("R9 still full", int'(full_flag), 1);
    // R8: clear the sticky flag
    step(0, 0, 0, 0);
    chk("R8 sticky", int'(ovr_flag), 1);
    step(0, 0, 0, 1);
    chk("R8 cleared", int'(ovr_flag), 0);
    // Drain; dropped byte 0xEE must never appear (R8)
    for (int n = 0; n < 18; n++) step(0, 0, 1, 0);
    chk("R3 drained", int'(data_vld), 0);
    // R11: pop when empty
    step(0, 0, 1, 0);
    chk("R11 empty pop", int'(data_vld), 0);
    step(1, 8'h5A, 0, 0);
    step(0, 0, 0, 0);
    chk("R11 next byte", int'(data_out), 8'h5A);
    step(0, 0, 1, 0);

    // Overrun while clear pulses: set wins (R8)
    do_reset();
    for (int n = 0; n < 17; n++) step(1, n, 0, 0);
    step(1, 1, 0, 1);
    chk("R8 set wins", int'(ovr_flag), 1);

    // Sweep all codes over every occupancy (R4, R5, R10)
    for (int c = 0; c < 8; c++) begin
      thr_code = c[2:0]; thr_ie = c[0]; full_ie = c[1];
      do_reset();
      for (int n = 0; n < 17; n++) step(1, n + 16 * c, 0, 0);
      if (c >= 6) chk("R5 disabled code", int'(thr_flag), 0);
      for (int n = 0; n < 17; n++) step(0, 0, 1, 0);
    end

    // Pseudo-random push/pop mix
    thr_code = 3'd2; thr_ie = 1; full_ie = 1;
    do_reset();
    lfsr = 32'h1ACE;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0] ^ 1'b1};
      step(lfsr[3] | lfsr[5], lfsr[15:8], lfsr[7] & lfsr[2], lfsr[11] & lfsr[12] & lfsr[13]);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule